// File: doc/BRIEF.md
# Spatial Region Generation Tracker

This block follows the access stream of a first-level data cache and keeps a small set-associative table of live access "generations". A generation is the run of accesses to one aligned spatial region. It opens with a trigger access that misses the table. It records the program counter of that trigger, the physical base of the region and, for each cache line inside the region, a two-bit saturating touch counter.

Before each accepted access, a multi-cycle scan walks every live generation. For every line whose touch counter is non-zero, the scan asks an external residency port whether that line is still cached or waiting in the miss queue. The first negative answer closes the generation. The block then emits a one-cycle pattern-commit write, keyed by the trigger program counter, and frees the table slot.

After the scan, the access is looked up. A hit records the touched line. A miss emits a trigger event and allocates a slot, chosen by a per-way recency bit. A global counter carries the number of table hits between successive triggers. Each live generation also ages by one for every access that goes to some other slot. Prefetch issue is left to the consumers of the trigger and commit outputs.

Top module: `region_gen_tracker`

## Requirements
- R1: The region number of an access is its virtual address divided by the region size (256 bytes by default). The line offset is the remainder divided by the line size (64 bytes), giving 4 lines per region. On a trigger both values appear on `trig_region` and `trig_offset`.
- R2: An access presented with `acc_pc_valid` low is consumed in one cycle and has no effect. `acc_ready` stays high, no trigger is produced, the hit counter is unchanged and no table slot is created.
- R3: An access whose region and secure bit match no live slot produces a one-cycle `trig_valid` pulse. The pulse carries the region, the offset, the PC and, on `trig_delta`, the number of table hits since the previous trigger. The hit counter then restarts from zero.
- R4: An access that hits a live slot (same region and same secure bit) produces no trigger and raises the hit counter by one.
- R5: Before each accepted access, every non-zero touch counter of every live slot is queried on the residency port. The query address is the physical region base plus offset times the line size.
- R6: A negative residency answer (`rs_present` low) ends that generation. The next cycle carries `commit_valid` with the trigger PC, the physical region base and a mask of touched lines (bit i set for line offset i). The slot is freed, so a later access to that region triggers again.
- R7: A positive residency answer never produces a commit.
- R8: `commit_age` equals the number of accepted accesses with a valid PC that went to other slots while the generation was live. It saturates at 15.
- R9: Within a set, a trigger fills an empty way first. Otherwise it replaces a way whose recency bit is clear. Every hit or fill sets the touched way's bit, and when all bits of a set would be set, only the touched one is kept.
- R10: `acc_ready` is low from the cycle after a valid-PC access is accepted until its table update completes. `rq_valid` is low while `acc_ready` is high. Once raised, `rq_valid` holds its address stable until a cycle with `rs_valid`.
- R11: After reset, `acc_ready` is high and `trig_valid`, `commit_valid` and `rq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block can take an access |
| acc_addr | input | ADDR_W | Virtual access address |
| acc_paddr | input | ADDR_W | Physical access address |
| acc_pc_valid | input | 1 | PC field is meaningful |
| acc_pc | input | PC_W | Program counter of the access |
| acc_secure | input | 1 | Secure address space |
| rq_valid | output | 1 | Residency query pending |
| rq_addr | output | ADDR_W | Line address being queried |
| rq_secure | output | 1 | Secure bit of the query |
| rs_valid | input | 1 | Residency answer present |
| rs_present | input | 1 | Line is cached or in the miss queue |
| trig_valid | output | 1 | Trigger event pulse |
| trig_region | output | ADDR_W-log2(REGION_BYTES) | Region number of the trigger |
| trig_offset | output | log2(lines per region) | Line offset of the trigger |
| trig_pc | output | PC_W | PC of the trigger |
| trig_delta | output | CNT_W | Table hits since the previous trigger |
| commit_valid | output | 1 | Pattern-commit write pulse |
| commit_pc | output | PC_W | Key of the commit (trigger PC) |
| commit_base | output | ADDR_W | Physical base of the ended region |
| commit_mask | output | lines per region | Lines touched during the generation |
| commit_age | output | AGE_W | Sequence counter of the ended generation |

## Verification
The main function is driven through a stimulus table that mixes first touches, repeat touches, an access without a PC, and three regions that map to one set. The table tells apart a hit from a trigger, shows that hits between triggers are counted, and shows that the recency bits pick the right way to replace. A directed section then withholds residency of one recorded line: a one-line region must close with the right base, mask and age, and a two-line region must close only on the line that is missing. A region that is re-entered after a commit must trigger again. An access that differs only in its secure bit must not hit.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SCAN,
    S_WAIT,
    S_APPLY
  } stg_state_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // two-bit saturating touch counter
  function automatic logic [1:0] touch_inc(input logic [1:0] c);
    return (c == 2'b11) ? c : c + 2'd1;
  endfunction

endpackage

// File: rtl/stg_way_lookup.sv
`timescale 1ns/1ps
module stg_way_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 22,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]       way_sec,
  input  logic [WAYS-1:0]       way_mru,
  input  logic [TAG_W-1:0]      key_tag,
  input  logic                  key_sec,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      victim_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_sec[w] == key_sec) &&
                        (way_tag[w*TAG_W +: TAG_W] == key_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // empty way first, otherwise the lowest way with a clear recency bit
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !way_valid[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !way_mru[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stg_mru_next.sv
`timescale 1ns/1ps
module stg_mru_next #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  mru_in,
  input  logic [WAY_W-1:0] touch,
  output logic [WAYS-1:0]  mru_out
);

  logic [WAYS-1:0] touch_bit;
  logic [WAYS-1:0] merged;

  assign touch_bit = WAYS'(1) << touch;
  assign merged    = mru_in | touch_bit;
  assign mru_out   = (&merged) ? touch_bit : merged;

endmodule

// File: rtl/stg_scan_ptr.sv
`timescale 1ns/1ps
module stg_scan_ptr #(
  parameter int ENTRIES = 8,
  parameter int LINES   = 4,
  parameter int ENT_W   = 3,
  parameter int OFF_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_line,
  input  logic             step_entry,
  output logic [ENT_W-1:0] ent,
  output logic [OFF_W-1:0] line,
  output logic             wrap
);

  logic end_row;

  assign end_row = step_entry || (step_line && (line == OFF_W'(LINES - 1)));
  assign wrap    = end_row && (ent == ENT_W'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ent  <= '0;
      line <= '0;
    end else if (end_row) begin
      line <= '0;
      ent  <= wrap ? '0 : ent + 1'b1;
    end else if (step_line) begin
      line <= line + 1'b1;
    end
  end

endmodule

// File: rtl/region_gen_tracker.sv
`timescale 1ns/1ps
module region_gen_tracker #(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 12,
  parameter int REGION_BYTES = 256,
  parameter int LINE_BYTES   = 64,
  parameter int SETS         = 4,
  parameter int WAYS         = 2,
  parameter int CNT_W        = 8,
  parameter int AGE_W        = 4,
  localparam int LINES   = REGION_BYTES / LINE_BYTES,
  localparam int REG_LG  = $clog2(REGION_BYTES),
  localparam int LINE_LG = $clog2(LINE_BYTES),
  localparam int OFF_W   = $clog2(LINES),
  localparam int RGN_W   = ADDR_W - REG_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] acc_paddr,
  input  logic              acc_pc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic              acc_secure,
  output logic              rq_valid,
  output logic [ADDR_W-1:0] rq_addr,
  output logic              rq_secure,
  input  logic              rs_valid,
  input  logic              rs_present,
  output logic              trig_valid,
  output logic [RGN_W-1:0]  trig_region,
  output logic [OFF_W-1:0]  trig_offset,
  output logic [PC_W-1:0]   trig_pc,
  output logic [CNT_W-1:0]  trig_delta,
  output logic              commit_valid,
  output logic [PC_W-1:0]   commit_pc,
  output logic [ADDR_W-1:0] commit_base,
  output logic [LINES-1:0]  commit_mask,
  output logic [AGE_W-1:0]  commit_age
);
  import stg_pkg::*;

  localparam int SET_W    = $clog2(SETS);
  localparam int ENTRIES  = SETS * WAYS;
  localparam int ENT_W    = $clog2(ENTRIES);
  localparam int WAY_W    = $clog2(WAYS);
  localparam int TAG_W    = RGN_W - SET_W;
  localparam int CNT_BITS = 2 * LINES;

  if (!is_pow2(REGION_BYTES) || !is_pow2(LINE_BYTES) || !is_pow2(SETS) ||
      !is_pow2(WAYS) || LINES < 2 || SETS < 2 || WAYS < 2) begin : g_cfg_bad
    $error("region_gen_tracker: sizes must be powers of two, each at least 2");
  end

  // ---------------- address arithmetic ----------------
  function automatic logic [RGN_W-1:0] region_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:REG_LG];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[REG_LG-1:LINE_LG];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [RGN_W-1:0] base,
                                                   input logic [OFF_W-1:0] off);
    return {base, off, LINE_LG'(0)};
  endfunction

  logic unused_low;
  assign unused_low = ^{acc_addr[LINE_LG-1:0], acc_paddr[REG_LG-1:0]};

  // ---------------- state ----------------
  stg_state_e        state;
  logic [RGN_W-1:0]  a_region;
  logic [OFF_W-1:0]  a_off;
  logic [PC_W-1:0]   a_pc;
  logic              a_sec;
  logic [RGN_W-1:0]  a_pbase;
  logic [CNT_W-1:0]  hits_since_trig;

  logic [ENTRIES-1:0]  tv;
  logic [ENTRIES-1:0]  t_sec;
  logic [ENTRIES-1:0]  t_mru;
  logic [TAG_W-1:0]    t_tag  [ENTRIES];
  logic [PC_W-1:0]     t_pc   [ENTRIES];
  logic [RGN_W-1:0]    t_base [ENTRIES];
  logic [CNT_BITS-1:0] t_cnt  [ENTRIES];
  logic [AGE_W-1:0]    t_age  [ENTRIES];

  // ---------------- lookup of the latched access ----------------
  logic [SET_W-1:0]       a_set;
  logic [TAG_W-1:0]       a_tag;
  logic [WAYS-1:0]        set_valid, set_sec, set_mru, mru_next, hit_vec;
  logic [WAYS*TAG_W-1:0]  set_tag;
  logic                   l_hit;
  logic [WAY_W-1:0]       hit_way, vic_way, touch_way;
  logic [ENT_W-1:0]       touch_idx;

  assign a_set = a_region[SET_W-1:0];
  assign a_tag = a_region[RGN_W-1:SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w]               = tv[{a_set, WAY_W'(w)}];
      set_sec[w]                 = t_sec[{a_set, WAY_W'(w)}];
      set_mru[w]                 = t_mru[{a_set, WAY_W'(w)}];
      set_tag[w*TAG_W +: TAG_W]  = t_tag[{a_set, WAY_W'(w)}];
    end
  end

  stg_way_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .way_valid (set_valid),
    .way_tag   (set_tag),
    .way_sec   (set_sec),
    .way_mru   (set_mru),
    .key_tag   (a_tag),
    .key_sec   (a_sec),
    .hit_vec   (hit_vec),
    .hit       (l_hit),
    .hit_way   (hit_way),
    .victim_way(vic_way)
  );

  assign touch_way = l_hit ? hit_way : vic_way;
  assign touch_idx = {a_set, touch_way};

  stg_mru_next #(.WAYS(WAYS), .WAY_W(WAY_W)) u_mru (
    .mru_in (set_mru),
    .touch  (touch_way),
    .mru_out(mru_next)
  );

  // ---------------- end-of-generation scan ----------------
  logic [ENT_W-1:0] cur_e;
  logic [OFF_W-1:0] cur_l;
  logic             scan_wrap, need_q, step_line, step_entry;
  logic             take, gen_end;
  logic [LINES-1:0] cur_mask;

  assign acc_ready  = (state == S_IDLE);
  assign take       = acc_valid && acc_ready && acc_pc_valid;
  assign need_q     = tv[cur_e] && (t_cnt[cur_e][{cur_l, 1'b0} +: 2] != 2'b00);
  assign gen_end    = (state == S_WAIT) && rs_valid && !rs_present;
  assign step_entry = ((state == S_SCAN) && !tv[cur_e]) || gen_end;
  assign step_line  = ((state == S_SCAN) && tv[cur_e] && !need_q) ||
                      ((state == S_WAIT) && rs_valid && rs_present);

  assign rq_valid  = (state == S_WAIT);
  assign rq_addr   = line_addr(t_base[cur_e], cur_l);
  assign rq_secure = t_sec[cur_e];

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      cur_mask[l] = (t_cnt[cur_e][2*l +: 2] != 2'b00);
    end
  end

  stg_scan_ptr #(.ENTRIES(ENTRIES), .LINES(LINES), .ENT_W(ENT_W), .OFF_W(OFF_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (take),
    .step_line (step_line),
    .step_entry(step_entry),
    .ent       (cur_e),
    .line      (cur_l),
    .wrap      (scan_wrap)
  );

  // ---------------- control and event outputs ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      a_region        <= '0;
      a_off           <= '0;
      a_pc            <= '0;
      a_sec           <= 1'b0;
      a_pbase         <= '0;
      hits_since_trig <= '0;
      trig_valid      <= 1'b0;
      trig_region     <= '0;
      trig_offset     <= '0;
      trig_pc         <= '0;
      trig_delta      <= '0;
      commit_valid    <= 1'b0;
      commit_pc       <= '0;
      commit_base     <= '0;
      commit_mask     <= '0;
      commit_age      <= '0;
    end else begin
      trig_valid   <= 1'b0;
      commit_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (take) begin
          a_region <= region_of(acc_addr);
          a_off    <= offset_of(acc_addr);
          a_pc     <= acc_pc;
          a_sec    <= acc_secure;
          a_pbase  <= region_of(acc_paddr);
          state    <= S_SCAN;
        end
        S_SCAN: begin
          if (need_q)         state <= S_WAIT;
          else if (scan_wrap) state <= S_APPLY;
        end
        S_WAIT: if (rs_valid) begin
          state <= scan_wrap ? S_APPLY : S_SCAN;
        end
        S_APPLY: begin
          state <= S_IDLE;
          if (l_hit) begin
            if (hits_since_trig != '1) hits_since_trig <= hits_since_trig + 1'b1;
          end else begin
            trig_valid      <= 1'b1;
            trig_region     <= a_region;
            trig_offset     <= a_off;
            trig_pc         <= a_pc;
            trig_delta      <= hits_since_trig;
            hits_since_trig <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (gen_end) begin
        commit_valid <= 1'b1;
        commit_pc    <= t_pc[cur_e];
        commit_base  <= line_addr(t_base[cur_e], '0);
        commit_mask  <= cur_mask;
        commit_age   <= t_age[cur_e];
      end
    end
  end

  // ---------------- table storage ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv    <= '0;
      t_sec <= '0;
      t_mru <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        t_tag[e]  <= '0;
        t_pc[e]   <= '0;
        t_base[e] <= '0;
        t_cnt[e]  <= '0;
        t_age[e]  <= '0;
      end
    end else begin
      if (gen_end) tv[cur_e] <= 1'b0;
      if (state == S_APPLY) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (tv[e] && (ENT_W'(e) != touch_idx) && (t_age[e] != '1))
            t_age[e] <= t_age[e] + 1'b1;
        end
        if (l_hit) begin
          t_cnt[touch_idx][{a_off, 1'b0} +: 2] <=
            touch_inc(t_cnt[touch_idx][{a_off, 1'b0} +: 2]);
        end else begin
          tv[touch_idx]     <= 1'b1;
          t_tag[touch_idx]  <= a_tag;
          t_sec[touch_idx]  <= a_sec;
          t_pc[touch_idx]   <= a_pc;
          t_base[touch_idx] <= a_pbase;
          t_cnt[touch_idx]  <= CNT_BITS'(1) << {a_off, 1'b0};
          t_age[touch_idx]  <= '0;
        end
        for (int w = 0; w < WAYS; w++) begin
          t_mru[{a_set, WAY_W'(w)}] <= mru_next[w];
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_nopc_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && !acc_pc_valid |=> acc_ready && !trig_valid);

  p_trig_at_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> acc_ready && !commit_valid);

  p_commit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(rs_valid && !rs_present));

  p_commit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_mask != '0);

  p_present_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_present |=> !commit_valid);

  p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_APPLY) |-> $onehot0(hit_vec));

  p_busy_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && acc_pc_valid |=> !acc_ready);

  p_no_query_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !rq_valid);

  p_query_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rs_valid |=> rq_valid && $stable(rq_addr));

endmodule

// File: tb/region_gen_tracker_bench.sv
`timescale 1ns/1ps
module region_gen_tracker_bench;

  localparam logic [31:0] PBIAS = 32'h1000_0000;
  localparam int RBYTES = 256;
  localparam int LBYTES = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_paddr = '0;
  logic        acc_pc_valid = 1'b0;
  logic [11:0] acc_pc = '0;
  logic        acc_secure = 1'b0;
  logic        rq_valid;
  logic [31:0] rq_addr;
  logic        rq_secure;
  logic        rs_valid = 1'b0;
  logic        rs_present = 1'b0;
  logic        trig_valid;
  logic [23:0] trig_region;
  logic [1:0]  trig_offset;
  logic [11:0] trig_pc;
  logic [7:0]  trig_delta;
  logic        commit_valid;
  logic [11:0] commit_pc;
  logic [31:0] commit_base;
  logic [3:0]  commit_mask;
  logic [3:0]  commit_age;

  region_gen_tracker u_region_gen_tracker (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_paddr(acc_paddr), .acc_pc_valid(acc_pc_valid), .acc_pc(acc_pc),
    .acc_secure(acc_secure),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_secure(rq_secure),
    .rs_valid(rs_valid), .rs_present(rs_present),
    .trig_valid(trig_valid), .trig_region(trig_region), .trig_offset(trig_offset),
    .trig_pc(trig_pc), .trig_delta(trig_delta),
    .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_base(commit_base),
    .commit_mask(commit_mask), .commit_age(commit_age)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int trig_cnt = 0;
  int commit_cnt = 0;
  int q_cnt = 0;
  logic [23:0] l_region;
  logic [1:0]  l_off;
  logic [11:0] l_pc, c_pc;
  logic [7:0]  l_delta;
  logic [31:0] c_base;
  logic [3:0]  c_mask, c_age;
  logic [31:0] ev_addr = '0;
  bit          ev_on = 1'b0;
  logic [31:0] watch_addr = '1;
  bit          watch_hit = 1'b0;
  bit          busy_seen;

  // event monitor and residency responder, both away from the active edge
  always @(negedge clk) begin
    if (trig_valid) begin
      trig_cnt++;
      l_region = trig_region; l_off = trig_offset; l_pc = trig_pc; l_delta = trig_delta;
    end
    if (commit_valid) begin
      commit_cnt++;
      c_pc = commit_pc; c_base = commit_base; c_mask = commit_mask; c_age = commit_age;
    end
    if (rq_valid && !rs_valid) begin
      rs_valid   = 1'b1;
      rs_present = !(ev_on && rq_addr == ev_addr);
      q_cnt++;
      if (rq_addr == watch_addr) watch_hit = 1'b1;
    end else begin
      rs_valid = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input logic [31:0] a, input bit pcv,
                           input logic [11:0] pc, input bit sec);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_paddr = a + PBIAS;
    acc_pc_valid = pcv; acc_pc = pc; acc_secure = sec;
    @(negedge clk);
    acc_valid = 1'b0;
    busy_seen = !acc_ready;
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        pcv;
    logic [11:0] pc;
    logic        trig;
    logic [7:0]  delta;
  } vec_t;

  // set 1 holds regions 0x1, 0x9 and 0x11 in turn (R9)
  localparam vec_t VEC [10] = '{
    '{32'h0000_0140, 1'b1, 12'h011, 1'b1, 8'd0},
    '{32'h0000_0180, 1'b1, 12'h012, 1'b0, 8'd0},
    '{32'h0000_01C0, 1'b1, 12'h012, 1'b0, 8'd0},
    '{32'h0000_0940, 1'b0, 12'h0FF, 1'b0, 8'd0},
    '{32'h0000_0200, 1'b1, 12'h013, 1'b1, 8'd2},
    '{32'h0000_0940, 1'b1, 12'h014, 1'b1, 8'd0},
    '{32'h0000_1140, 1'b1, 12'h015, 1'b1, 8'd0},
    '{32'h0000_0900, 1'b1, 12'h016, 1'b0, 8'd0},
    '{32'h0000_0100, 1'b1, 12'h017, 1'b1, 8'd1},
    '{32'h0000_1100, 1'b1, 12'h018, 1'b1, 8'd0}
  };

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int t0, c0, q0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "acc_ready after reset", 64'(acc_ready), 64'd1);
    chk("R11", "trig_valid after reset", 64'(trig_valid), 64'd0);
    chk("R11", "commit_valid after reset", 64'(commit_valid), 64'd0);
    chk("R11", "rq_valid after reset", 64'(rq_valid), 64'd0);

    for (int i = 0; i < 10; i++) begin
      t0 = trig_cnt;
      do_access(VEC[i].addr, VEC[i].pcv, VEC[i].pc, 1'b0);
      if (VEC[i].pcv) chk("R10", $sformatf("busy after take v%0d", i), 64'(busy_seen), 64'd1);
      else            chk("R2",  $sformatf("ready kept v%0d", i), 64'(busy_seen), 64'd0);
      chk("R3 R4 R9", $sformatf("trigger count v%0d", i), 64'(trig_cnt - t0), 64'(VEC[i].trig));
      if (VEC[i].trig) begin
        chk("R1", $sformatf("region v%0d", i), 64'(l_region), 64'(VEC[i].addr / RBYTES));
        chk("R1", $sformatf("offset v%0d", i), 64'(l_off), 64'((VEC[i].addr % RBYTES) / LBYTES));
        chk("R3", $sformatf("pc v%0d", i), 64'(l_pc), 64'(VEC[i].pc));
        chk("R3 R4", $sformatf("delta v%0d", i), 64'(l_delta), 64'(VEC[i].delta));
      end
    end
    chk("R7", "no commit while all resident", 64'(commit_cnt), 64'd0);

    // R5 R6 R8: line 0 of region 2 goes missing
    ev_addr = PBIAS + 32'h200; ev_on = 1'b1; watch_addr = PBIAS + 32'h200;
    t0 = trig_cnt; c0 = commit_cnt;
    do_access(32'h0000_0300, 1'b1, 12'h021, 1'b0);
    chk("R5", "recorded line queried", 64'(watch_hit), 64'd1);
    chk("R6", "one commit", 64'(commit_cnt - c0), 64'd1);
    chk("R6", "commit pc", 64'(c_pc), 64'h013);
    chk("R6", "commit base", 64'(c_base), 64'(PBIAS + 32'h200));
    chk("R6", "commit mask", 64'(c_mask), 64'b0001);
    chk("R8", "commit age", 64'(c_age), 64'd5);
    chk("R3", "region 3 triggers", 64'(trig_cnt - t0), 64'd1);

    // R6 R7: ended region triggers again, resident lines commit nothing
    ev_on = 1'b0;
    t0 = trig_cnt; c0 = commit_cnt; q0 = q_cnt;
    do_access(32'h0000_0280, 1'b1, 12'h022, 1'b0);
    chk("R6", "freed region triggers again", 64'(trig_cnt - t0), 64'd1);
    chk("R1", "offset of re-trigger", 64'(l_off), 64'd2);
    chk("R7", "present answers commit nothing", 64'(commit_cnt - c0), 64'd0);
    chk("R5", "queries issued", 64'(q_cnt > q0), 64'd1);

    // R6: two-line region closes on its second line only
    do_access(32'h0000_02C0, 1'b1, 12'h023, 1'b0);
    ev_addr = PBIAS + 32'h2C0; ev_on = 1'b1;
    t0 = trig_cnt; c0 = commit_cnt;
    do_access(32'h0000_0300, 1'b1, 12'h024, 1'b0);
    chk("R4", "region 3 hit, no trigger", 64'(trig_cnt - t0), 64'd0);
    chk("R6", "two-line commit", 64'(commit_cnt - c0), 64'd1);
    chk("R6", "two-line mask", 64'(c_mask), 64'b1100);
    chk("R6", "two-line pc", 64'(c_pc), 64'h022);
    chk("R8", "fresh age", 64'(c_age), 64'd0);

    // R3: secure bit takes part in the match
    t0 = trig_cnt;
    do_access(32'h0000_0340, 1'b1, 12'h025, 1'b1);
    chk("R3", "secure mismatch triggers", 64'(trig_cnt - t0), 64'd1);
    chk("R4", "hits counted before trigger", 64'(l_delta), 64'd2);

    summary();
    $finish;
  end

endmodule